// File: doc/BRIEF.md
# Reset Sequence Controller

This block combines three reset requests into one internal core reset and one pull-down enable for a bidirectional, open-drain reset pad. The requests are the external reset level sensed at the pad (active low), a request from the low-voltage detector (active high, also used as the power-on request) and a one-cycle underflow pulse from the watchdog counter. The external and low-voltage requests act asynchronously: the pad is pulled low and the core is held in reset at once, even when the clock is stopped. Release is taken back through a two-flop synchronizer.

Each reset runs through three phases:

- **Active phase.** It lasts while the request is present. It is stretched to a minimum width when the request is short.
- **Delay phase.** It is counted in clock edges. In stand-alone mode the count starts at the end of the active phase. In USB mode the count runs only while the PLL lock input is high.
- **Fetch phase.** It lasts two cycles and presents the two reset-vector byte addresses.

The core reset is then released. Any new request during the delay or fetch phase starts the sequence again from the active phase.

The `ext_rst_n` input is the level driven onto the pad from outside, without this block's own pull-down. `usb_mode`, `pll_lock` and `wdg_uflow` are synchronous to `clk`. `usb_mode` is expected to be stable while a sequence runs.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `ext_rst_n` is low or `lvd_req` is high, `pin_pull_low` is 1 and `core_rst_n` is 0 with no clock edge needed, including when the clock is stopped.
- R2: For an external pulse that spans L rising edges, with L+3 <= MIN_W (default 16), the active phase ends on rising edge MIN_W counted from the assertion. The pulse is stretched to that width.
- R3: For an external pulse with L+3 > MIN_W, the active phase ends on the third rising edge after release, with no added stretch.
- R4: A one-cycle `wdg_uflow` pulse enters the active phase on the edge that samples it. The active phase lasts MIN_W more edges.
- R5: After `lvd_req` falls, the active phase lasts MIN_W edges counted from the first edge after release.
- R6: With `usb_mode`=0, the delay phase lasts SA_DELAY (default 512) edges. `pin_pull_low` stays 1 and `core_rst_n` stays 0 throughout.
- R7: With `usb_mode`=1, the delay phase ends on edge USB_DELAY (default 256) counted from the first edge that samples `pll_lock` high. While lock is low, the pin stays pulled low.
- R8: The fetch phase lasts two cycles with `vec_fetch`=1 and `pin_pull_low`=0. `vec_addr` is 16'hFFFE in the first cycle and 16'hFFFF in the second. `core_rst_n` rises on the next edge.
- R9: A request that arrives during the delay or fetch phase restarts the sequence from the active phase, with the same timing as from run state.
- R10: In run state, `core_rst_n`=1, `pin_pull_low`=0, `vec_fetch`=0 and `vec_addr`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| ext_rst_n | input | 1 | External reset level at the pad, active low, asynchronous |
| lvd_req | input | 1 | Low-voltage / power-on reset request, active high, asynchronous |
| wdg_uflow | input | 1 | Watchdog underflow pulse, one cycle, synchronous |
| usb_mode | input | 1 | 1 selects the PLL-lock-referenced delay |
| pll_lock | input | 1 | PLL lock indication, synchronous |
| pin_pull_low | output | 1 | Enables the open-drain pull-down on the reset pad |
| core_rst_n | output | 1 | Core reset, active low |
| vec_fetch | output | 1 | High during the two fetch cycles |
| vec_addr | output | 16 | Reset vector byte address during fetch, 0 otherwise |

## Verification
Every result is due at a rising edge that can be counted from the stimulus:

- **Delay phase.** It ends on edge x+D, where x is the edge that ends the active phase (MIN_W, L+3, 1+MIN_W or L+MIN_W after the stimulus) and D is the delay. In USB mode it ends on edge m+D when lock is raised in cycle m.
- **Fetch phase.** It occupies the two cycles after edge x+D.
- **Run state.** It is reached two edges after the fetch starts.

The bench drives inputs and samples outputs only at falling edges. It counts the samples with the pin pulled low, and records the falling-edge index of the first fetch and of the core release. It compares each with x+D-1, x+D and x+D+2. The asynchronous entry is sampled 1 ns after the request, with the clock running and with it stopped.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_DELAY  = 2'd1,
    PH_FETCH  = 2'd2,
    PH_RUN    = 2'd3
  } rsm_phase_e;

endpackage

// File: rtl/rsm_release_sync.sv
// Release synchronizer: cleared at once by the asynchronous request,
// returns 1 after STAGES rising edges with no request.
module rsm_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic released
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '0;
    else      chain[0] <= 1'b1;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain[i] <= 1'b0;
        else      chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign released = chain[STAGES-1];

endmodule

// File: rtl/rsm_active_timer.sv
// Counts edges spent in the active phase. Only the power-on request clears
// it asynchronously, so an external pulse is measured while it is held.
module rsm_active_timer #(
  parameter int MIN_W = 16
) (
  input  logic clk,
  input  logic por,
  input  logic in_active,
  input  logic clr,
  output logic done
);

  localparam int AW = (MIN_W > 2) ? $clog2(MIN_W) : 1;
  localparam logic [AW-1:0] LAST = AW'(MIN_W - 1);

  logic [AW-1:0] cnt;

  always_ff @(posedge clk or posedge por) begin
    if (por)                        cnt <= '0;
    else if (clr || !in_active)     cnt <= '0;
    else if (cnt != LAST)           cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);

endmodule

// File: rtl/rsm_delay_timer.sv
// Delay phase counter; the mode picks the length and whether PLL lock gates it.
module rsm_delay_timer #(
  parameter int SA_DELAY  = 512,
  parameter int USB_DELAY = 256
) (
  input  logic clk,
  input  logic arst,
  input  logic in_delay,
  input  logic usb_mode,
  input  logic pll_lock,
  output logic expire
);

  localparam int MAXD = (SA_DELAY > USB_DELAY) ? SA_DELAY : USB_DELAY;
  localparam int DW   = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic [DW-1:0] cnt;
  logic [DW-1:0] last;
  logic          run_en;

  assign last   = usb_mode ? DW'(USB_DELAY - 1) : DW'(SA_DELAY - 1);
  assign run_en = in_delay && (!usb_mode || pll_lock);

  always_ff @(posedge clk or posedge arst) begin
    if (arst)         cnt <= '0;
    else if (!run_en) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign expire = run_en && (cnt == last);

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsm_pkg::*;
#(
  parameter int                MIN_W       = 16,
  parameter int                SA_DELAY    = 512,
  parameter int                USB_DELAY   = 256,
  parameter int                SYNC_STAGES = 2,
  parameter int                FETCH_LEN   = 2,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              ext_rst_n,
  input  logic              lvd_req,
  input  logic              wdg_uflow,
  input  logic              usb_mode,
  input  logic              pll_lock,
  output logic              pin_pull_low,
  output logic              core_rst_n,
  output logic              vec_fetch,
  output logic [ADDR_W-1:0] vec_addr
);

  localparam int FW = (FETCH_LEN > 2) ? $clog2(FETCH_LEN) : 1;
  localparam logic [FW-1:0] FLAST = FW'(FETCH_LEN - 1);

  rsm_phase_e    phase;
  logic          arst;
  logic          released;
  logic          act_done;
  logic          leave_act;
  logic          dly_expire;
  logic [FW-1:0] fidx;

  assign arst = !ext_rst_n || lvd_req;

  rsm_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .arst     (arst),
    .released (released)
  );

  assign leave_act = (phase == PH_ACTIVE) && released && act_done && !wdg_uflow;

  rsm_active_timer #(.MIN_W(MIN_W)) u_act (
    .clk       (clk),
    .por       (lvd_req),
    .in_active (phase == PH_ACTIVE),
    .clr       (wdg_uflow || leave_act),
    .done      (act_done)
  );

  rsm_delay_timer #(.SA_DELAY(SA_DELAY), .USB_DELAY(USB_DELAY)) u_dly (
    .clk      (clk),
    .arst     (arst),
    .in_delay (phase == PH_DELAY),
    .usb_mode (usb_mode),
    .pll_lock (pll_lock),
    .expire   (dly_expire)
  );

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      phase <= PH_ACTIVE;
      fidx  <= '0;
    end else if (wdg_uflow) begin
      phase <= PH_ACTIVE;
      fidx  <= '0;
    end else begin
      unique case (phase)
        PH_ACTIVE: if (leave_act) phase <= PH_DELAY;
        PH_DELAY: begin
          fidx <= '0;
          if (dly_expire) phase <= PH_FETCH;
        end
        PH_FETCH: begin
          fidx <= fidx + 1'b1;
          if (fidx == FLAST) phase <= PH_RUN;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign pin_pull_low = (phase == PH_ACTIVE) || (phase == PH_DELAY);
  assign core_rst_n   = (phase == PH_RUN);
  assign vec_fetch    = (phase == PH_FETCH);
  assign vec_addr     = vec_fetch ? (VEC_BASE + {{(ADDR_W-FW){1'b0}}, fidx}) : '0;

endmodule

// File: rtl/rsm_checker.sv
module rsm_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              ext_rst_n,
  input logic              lvd_req,
  input logic              wdg_uflow,
  input logic              pin_pull_low,
  input logic              core_rst_n,
  input logic              vec_fetch,
  input logic [ADDR_W-1:0] vec_addr
);

  // R1
  ext_entry_chk: assert property (@(posedge clk) disable iff (lvd_req)
    !ext_rst_n |-> (pin_pull_low && !core_rst_n));

  // R4
  wdg_entry_chk: assert property (@(posedge clk) disable iff (lvd_req || !ext_rst_n)
    wdg_uflow |=> (pin_pull_low && !core_rst_n && !vec_fetch));

  // R8
  fetch_order_chk: assert property (@(posedge clk) disable iff (lvd_req || !ext_rst_n)
    (vec_fetch && vec_addr == 16'hFFFE && !wdg_uflow) |=> (vec_fetch && vec_addr == 16'hFFFF));

  // R8
  fetch_release_chk: assert property (@(posedge clk) disable iff (lvd_req || !ext_rst_n)
    (vec_fetch && vec_addr == 16'hFFFF && !wdg_uflow) |=> core_rst_n);

  // R6
  release_path_chk: assert property (@(posedge clk) disable iff (lvd_req)
    $rose(core_rst_n) |-> $past(vec_fetch));

  // R10
  run_quiet_chk: assert property (@(posedge clk) disable iff (lvd_req)
    core_rst_n |-> (!pin_pull_low && !vec_fetch && vec_addr == '0));

endmodule

bind rst_seq_ctrl rsm_checker #(.ADDR_W(ADDR_W)) u_rsm_chk (
  .clk          (clk),
  .ext_rst_n    (ext_rst_n),
  .lvd_req      (lvd_req),
  .wdg_uflow    (wdg_uflow),
  .pin_pull_low (pin_pull_low),
  .core_rst_n   (core_rst_n),
  .vec_fetch    (vec_fetch),
  .vec_addr     (vec_addr)
);

// File: tb/tb_rst_seq_ctrl.sv
`timescale 1ns/1ps
module tb_rst_seq_ctrl;

  localparam int MIN_W = 16;
  localparam int SA_D  = 512;
  localparam int USB_D = 256;

  logic        clk = 1'b0;
  logic        clk_en = 1'b1;
  logic        ext_rst_n = 1'b1;
  logic        lvd_req = 1'b0;
  logic        wdg_uflow = 1'b0;
  logic        usb_mode = 1'b0;
  logic        pll_lock = 1'b0;
  logic        pin_pull_low;
  logic        core_rst_n;
  logic        vec_fetch;
  logic [15:0] vec_addr;

  int n_chk = 0;
  int n_bad = 0;

  always begin
    #2.5;
    clk = clk_en ? ~clk : 1'b0;
  end

  rst_seq_ctrl dut (
    .clk          (clk),
    .ext_rst_n    (ext_rst_n),
    .lvd_req      (lvd_req),
    .wdg_uflow    (wdg_uflow),
    .usb_mode     (usb_mode),
    .pll_lock     (pll_lock),
    .pin_pull_low (pin_pull_low),
    .core_rst_n   (core_rst_n),
    .vec_fetch    (vec_fetch),
    .vec_addr     (vec_addr)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // src: 0 external pin, 1 low-voltage, 2 watchdog. Called at a falling edge.
  // exp_x: edge ending the active phase; lock_at > 0: falling edge where lock rises.
  task automatic run_seq(input int src, input int len, input int lock_at,
                         input int exp_x, input int dly, input string rq);
    int  n_pin = 0;
    int  ff = 0;
    int  nrun = 0;
    int  e;
    bit  addr_ok = 1'b1;
    case (src)
      0:       ext_rst_n = 1'b0;
      1:       lvd_req   = 1'b1;
      default: wdg_uflow = 1'b1;
    endcase
    for (int k = 1; k < 4000; k++) begin
      @(negedge clk);
      if (pin_pull_low) n_pin++;
      if (vec_fetch) begin
        if (ff == 0) begin
          ff = k;
          if (vec_addr != 16'hFFFE || pin_pull_low) addr_ok = 1'b0;
        end else if (k == ff + 1 && (vec_addr != 16'hFFFF || pin_pull_low)) addr_ok = 1'b0;
      end
      if (core_rst_n) begin
        nrun = k;
        break;
      end
      if (src == 2 && k == 1) wdg_uflow = 1'b0;
      if (src == 0 && k == len) ext_rst_n = 1'b1;
      if (src == 1 && k == len) lvd_req = 1'b0;
      if (k == lock_at) pll_lock = 1'b1;
    end
    e = (lock_at > 0) ? lock_at + dly : exp_x + dly;
    check(n_pin == e - 1, rq, "pin low cycles", n_pin, e - 1);
    check(ff == e, "R8", "first fetch cycle", ff, e);
    check(nrun == e + 2, "R8", "core release cycle", nrun, e + 2);
    check(addr_ok, "R8", "fetch address order", int'(addr_ok), 1);
  endtask

  task automatic t_power_on();
    #1 lvd_req = 1'b1;
    repeat (3) @(negedge clk);
    check(pin_pull_low == 1'b1, "R1", "pin during lvd", int'(pin_pull_low), 1);
    check(core_rst_n == 1'b0, "R1", "core during lvd", int'(core_rst_n), 0);
    check(vec_fetch == 1'b0, "R8", "no fetch during lvd", int'(vec_fetch), 0);
    run_seq(1, 5, 0, 5 + MIN_W, SA_D, "R5");
  endtask

  task automatic t_run_quiet();
    bit ok = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!core_rst_n || pin_pull_low || vec_fetch || vec_addr != 16'h0) ok = 1'b0;
    end
    check(ok, "R10", "steady run outputs", int'(ok), 1);
  endtask

  task automatic t_short_ext();
    @(negedge clk);
    ext_rst_n = 1'b0;
    #1;
    check(pin_pull_low == 1'b1 && core_rst_n == 1'b0, "R1", "async entry",
          int'(pin_pull_low), 1);
    run_seq(0, 4, 0, MIN_W, SA_D, "R2");
  endtask

  task automatic t_long_ext();
    @(negedge clk);
    run_seq(0, 40, 0, 43, SA_D, "R3");
  endtask

  task automatic t_wdg();
    @(negedge clk);
    run_seq(2, 1, 0, 1 + MIN_W, SA_D, "R4");
  endtask

  task automatic t_usb_locked();
    @(negedge clk);
    usb_mode = 1'b1;
    pll_lock = 1'b1;
    run_seq(0, 4, 0, MIN_W, USB_D, "R7");
  endtask

  task automatic t_usb_late_lock();
    @(negedge clk);
    pll_lock = 1'b0;
    run_seq(0, 4, 100, MIN_W, USB_D, "R7");
    usb_mode = 1'b0;
  endtask

  task automatic t_restart_delay();
    @(negedge clk);
    wdg_uflow = 1'b1;
    @(negedge clk);
    wdg_uflow = 1'b0;
    repeat (100) @(negedge clk);
    check(pin_pull_low && !core_rst_n, "R9", "in delay before restart",
          int'(pin_pull_low), 1);
    run_seq(0, 4, 0, MIN_W, SA_D, "R9");
  endtask

  task automatic t_restart_fetch();
    int guard = 0;
    @(negedge clk);
    wdg_uflow = 1'b1;
    @(negedge clk);
    wdg_uflow = 1'b0;
    while (!vec_fetch && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(vec_fetch == 1'b1, "R6", "fetch reached", int'(vec_fetch), 1);
    run_seq(2, 1, 0, 1 + MIN_W, SA_D, "R9");
  endtask

  task automatic t_clock_stopped();
    int guard = 0;
    @(negedge clk);
    clk_en = 1'b0;
    #20 ext_rst_n = 1'b0;
    #1;
    check(pin_pull_low == 1'b1, "R1", "pin with clock stopped", int'(pin_pull_low), 1);
    check(core_rst_n == 1'b0, "R1", "core with clock stopped", int'(core_rst_n), 0);
    #5 ext_rst_n = 1'b1;
    clk_en = 1'b1;
    while (!core_rst_n && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(core_rst_n == 1'b1, "R1", "recovery after stopped clock", int'(core_rst_n), 1);
  endtask

  initial begin
    t_power_on();
    t_run_quiet();
    t_short_ext();
    t_long_ext();
    t_wdg();
    t_usb_locked();
    t_usb_late_lock();
    t_restart_delay();
    t_restart_fetch();
    t_clock_stopped();
    t_run_quiet();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #900000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule